// File: doc/BRIEF.md
# Low-Power Mode Wake-Up Controller

This block sequences the power modes of a small processor core. Starting from Normal operation, a sleep instruction puts the core into one of two low-power modes. A mode-select bit picks which one. In Idle the oscillator keeps running and only the CPU clock is gated. In Sleep both the oscillator and the CPU clock stop.

Each wake source acts differently depending on the mode:
- An external active-low sleep pin releases Sleep only. It is sampled through a two-stage synchronizer, and a configuration bit makes it act on a falling edge or on a high level.
- A release from Sleep starts a programmable warm-up count. While it runs, the oscillator is enabled and the CPU clock is still held off. When it ends, the core resumes at the next instruction.
- An enabled interrupt request, or a watchdog interrupt request, wakes the core from Idle only. The global interrupt enable decides between resuming in line and branching to the interrupt vector.
- An interrupt that has no effect is still recorded in a sticky per-source flag.
- The reset pin and a watchdog timeout force a reset request from any mode. They take precedence over every other event.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After block reset, `pmMode` is 0 (Normal), `oscEn` and `cpuClkEn` are 1, `resumeNext`, `takeVector` and `resetReq` are 0, and `pendFlags` is 0.
- R2: In Normal, a cycle with `sleepInsn`=1 and `modeSel`=0 moves the block to Idle at the next edge: `pmMode`=1, `oscEn`=1, `cpuClkEn`=0.
- R3: In Normal, a cycle with `sleepInsn`=1 and `modeSel`=1 moves the block to Sleep at the next edge, provided `edgeMode`=1 or the synchronized pin reads low. In Sleep, `pmMode`=2, `oscEn`=0 and `cpuClkEn`=0.
- R4: With `edgeMode`=0 and the synchronized pin high, a sleep instruction with `modeSel`=1 is ignored and the block stays in Normal with `cpuClkEn`=1.
- R5: In Sleep, a falling edge of `sleepPinN` (when `edgeMode`=1) or a high level (when `edgeMode`=0) starts warm-up. `pmMode` reads 3 after the third rising clock edge following the pin change, and still reads 2 after the second.
- R6: Warm-up lasts max(`warmLen`,1) cycles with `oscEn`=1 and `cpuClkEn`=0. The block then returns to Normal, and `resumeNext` is high for exactly that first Normal cycle.
- R7: `sleepPinN` has no effect in Normal or Idle.
- R8: Interrupt requests and `wdtIrq` have no effect in Sleep or warm-up. `pendFlags[i]` is set by `irqReq[i]` in any mode, is cleared by `flagClr[i]`, and the set takes precedence over the clear.
- R9: In Idle, a request with `irqReq[i]`=1 and `irqEn[i]`=1, or `wdtIrq`=1, returns the block to Normal at the next edge. In that first Normal cycle `resumeNext` is high if `globalIe`=0, and `takeVector` is high if `globalIe`=1. A request whose enable bit is 0 leaves Idle in place.
- R10: `resetPinN`=0 or `wdtTimeout`=1 in any mode puts the block in Normal with both enables high and `resetReq` high at the next edge. This overrides any wake or mode change in the same cycle.
- R11: `resumeNext` and `takeVector` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| sleepInsn | input | 1 | One-cycle strobe: sleep instruction executed |
| modeSel | input | 1 | 1 selects Sleep, 0 selects Idle |
| edgeMode | input | 1 | 1 makes the pin release edge-sensitive, 0 level-sensitive |
| sleepPinN | input | 1 | Active-low external sleep/release pin, asynchronous |
| resetPinN | input | 1 | Active-low reset pin (synchronous) |
| wdtTimeout | input | 1 | Watchdog timeout |
| wdtIrq | input | 1 | Watchdog interrupt request, always enabled |
| irqReq | input | NUM_IRQ | Interrupt requests |
| irqEn | input | NUM_IRQ | Per-source interrupt enables |
| globalIe | input | 1 | Global interrupt enable |
| flagClr | input | NUM_IRQ | Clears recorded request flags |
| warmLen | input | WARM_W | Warm-up length in cycles |
| oscEn | output | 1 | Oscillator enable |
| cpuClkEn | output | 1 | CPU clock enable |
| pmMode | output | 2 | 0 Normal, 1 Idle, 2 Sleep, 3 warm-up |
| resumeNext | output | 1 | Pulse: continue at next instruction |
| takeVector | output | 1 | Pulse: branch to interrupt vector |
| resetReq | output | 1 | Pulse: reset request |
| pendFlags | output | NUM_IRQ | Recorded interrupt request flags |

## Verification
Two pairs of functions can fall in the same cycle, and each pair pits a reset source against a wake.

In the first pair, a reset source coincides with the end of warm-up. The bench raises `wdtTimeout` in the last warm-up cycle. It expects `resetReq` high with `resumeNext` low, and Normal mode at the next edge.

In the second pair, the reset pin falls in the very cycle an enabled interrupt wakes Idle with the global enable on. Here the bench expects `resetReq` in place of `takeVector`.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL = 2'd0,
    PM_IDLE   = 2'd1,
    PM_SLEEP  = 2'd2,
    PM_WARM   = 2'd3
  } pmState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startWarm;
    logic resume;
    logic vector;
    logic rstHit;
  } pmStrobe_t;

endpackage

// File: rtl/pwr_wake_dp.sv
module pwr_wake_dp
  import pwr_wake_pkg::*;
#(
  parameter int NUM_IRQ = 4,
  parameter int WARM_W  = 8,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sleepPinN,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic [NUM_IRQ-1:0] irqEn,
  input  logic               wdtIrq,
  input  logic [NUM_IRQ-1:0] flagClr,
  input  logic [WARM_W-1:0]  warmLen,
  input  pmStrobe_t          stb,
  input  logic               inWarm,
  output logic               relLvl,
  output logic               relFall,
  output logic               irqWake,
  output logic               warmDone,
  output logic [NUM_IRQ-1:0] pendFlags,
  output logic               resumeNext,
  output logic               takeVector,
  output logic               resetReq
);

  logic [SYNC_N-1:0] syncQ;
  logic              edgeQ;
  logic [WARM_W-1:0] warmCnt;

  // pin synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= 1'b1;
    else       syncQ[0] <= sleepPinN;
  end

  for (genvar s = 1; s < SYNC_N; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= 1'b1;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeQ <= 1'b1;
    else       edgeQ <= syncQ[SYNC_N-1];
  end

  assign relLvl  = syncQ[SYNC_N-1];
  assign relFall = edgeQ & ~syncQ[SYNC_N-1];
  assign irqWake = (|(irqReq & irqEn)) | wdtIrq;

  // warm-up down-counter, loaded on release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            warmCnt <= '0;
    else if (stb.startWarm)               warmCnt <= warmLen;
    else if (inWarm && warmCnt != '0)     warmCnt <= warmCnt - 1'b1;
  end

  assign warmDone = inWarm && (warmCnt <= WARM_W'(1));

  // sticky request flags, set wins over clear
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           pendFlags[i] <= 1'b0;
      else if (irqReq[i])  pendFlags[i] <= 1'b1;
      else if (flagClr[i]) pendFlags[i] <= 1'b0;
    end
  end

  // registered one-cycle outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resumeNext <= 1'b0;
      takeVector <= 1'b0;
      resetReq   <= 1'b0;
    end else begin
      resumeNext <= stb.resume;
      takeVector <= stb.vector;
      resetReq   <= stb.rstHit;
    end
  end

  AST_RESET_FLAG: assert property (@(posedge clk) disable iff (!rstN) stb.rstHit |=> resetReq); // R10
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(resumeNext && takeVector)); // R11
  AST_FLAG_RECORD: assert property (@(posedge clk) disable iff (!rstN) (|irqReq) |=> (|pendFlags)); // R8

endmodule

// File: rtl/pwr_wake_ctrl_fsm.sv
module pwr_wake_ctrl_fsm
  import pwr_wake_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sleepInsn,
  input  logic      modeSel,
  input  logic      edgeMode,
  input  logic      resetPinN,
  input  logic      wdtTimeout,
  input  logic      globalIe,
  input  logic      relLvl,
  input  logic      relFall,
  input  logic      irqWake,
  input  logic      warmDone,
  output pmState_t  state,
  output pmStrobe_t stb
);

  pmState_t nxt;
  logic     resetHit;
  logic     relWake;

  assign resetHit = !resetPinN || wdtTimeout;
  assign relWake  = edgeMode ? relFall : relLvl;

  always_comb begin
    nxt = state;
    stb = '0;
    unique case (state)
      PM_NORMAL: begin
        if (sleepInsn) begin
          if (!modeSel)                  nxt = PM_IDLE;
          else if (edgeMode || !relLvl)  nxt = PM_SLEEP;
        end
      end
      PM_IDLE: begin
        if (irqWake) begin
          nxt = PM_NORMAL;
          if (globalIe) stb.vector = 1'b1;
          else          stb.resume = 1'b1;
        end
      end
      PM_SLEEP: begin
        if (relWake) begin
          nxt           = PM_WARM;
          stb.startWarm = 1'b1;
        end
      end
      PM_WARM: begin
        if (warmDone) begin
          nxt        = PM_NORMAL;
          stb.resume = 1'b1;
        end
      end
      default: nxt = PM_NORMAL;
    endcase
    if (resetHit) begin
      nxt        = PM_NORMAL;
      stb        = '0;
      stb.rstHit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PM_NORMAL;
    else       state <= nxt;
  end

  AST_RESET_NORMAL: assert property (@(posedge clk) disable iff (!rstN) resetHit |=> state == PM_NORMAL); // R10
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rstN) (state == PM_SLEEP && !relWake && !resetHit) |=> state == PM_SLEEP); // R8
  AST_LEVEL_GATE: assert property (@(posedge clk) disable iff (!rstN) (state == PM_NORMAL && sleepInsn && modeSel && !edgeMode && relLvl && !resetHit) |=> state == PM_NORMAL); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN) (state == PM_IDLE && !irqWake && !resetHit) |=> state == PM_IDLE); // R7

endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_wake_pkg::*;
#(
  parameter int NUM_IRQ = 4,
  parameter int WARM_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sleepInsn,
  input  logic               modeSel,
  input  logic               edgeMode,
  input  logic               sleepPinN,
  input  logic               resetPinN,
  input  logic               wdtTimeout,
  input  logic               wdtIrq,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic [NUM_IRQ-1:0] irqEn,
  input  logic               globalIe,
  input  logic [NUM_IRQ-1:0] flagClr,
  input  logic [WARM_W-1:0]  warmLen,
  output logic               oscEn,
  output logic               cpuClkEn,
  output logic [1:0]         pmMode,
  output logic               resumeNext,
  output logic               takeVector,
  output logic               resetReq,
  output logic [NUM_IRQ-1:0] pendFlags
);

  pmState_t  state;
  pmStrobe_t stb;
  logic      relLvl, relFall, irqWake, warmDone;

  pwr_wake_ctrl_fsm u_fsm (
    .clk(clk), .rstN(rstN), .sleepInsn(sleepInsn), .modeSel(modeSel),
    .edgeMode(edgeMode), .resetPinN(resetPinN), .wdtTimeout(wdtTimeout),
    .globalIe(globalIe), .relLvl(relLvl), .relFall(relFall),
    .irqWake(irqWake), .warmDone(warmDone), .state(state), .stb(stb)
  );

  pwr_wake_dp #(.NUM_IRQ(NUM_IRQ), .WARM_W(WARM_W), .SYNC_N(2)) u_dp (
    .clk(clk), .rstN(rstN), .sleepPinN(sleepPinN), .irqReq(irqReq),
    .irqEn(irqEn), .wdtIrq(wdtIrq), .flagClr(flagClr), .warmLen(warmLen),
    .stb(stb), .inWarm(state == PM_WARM), .relLvl(relLvl), .relFall(relFall),
    .irqWake(irqWake), .warmDone(warmDone), .pendFlags(pendFlags),
    .resumeNext(resumeNext), .takeVector(takeVector), .resetReq(resetReq)
  );

  assign oscEn    = (state != PM_SLEEP);
  assign cpuClkEn = (state == PM_NORMAL);
  assign pmMode   = state;

endmodule

// File: tb/pwr_wake_ctrl_bench.sv
module pwr_wake_ctrl_bench;

  localparam int NIRQ = 4;
  localparam int WW   = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepInsn = 1'b0, modeSel = 1'b0, edgeMode = 1'b0;
  logic sleepPinN = 1'b1, resetPinN = 1'b1, wdtTimeout = 1'b0, wdtIrq = 1'b0;
  logic [NIRQ-1:0] irqReq = '0, irqEn = '0, flagClr = '0;
  logic globalIe = 1'b0;
  logic [WW-1:0] warmLen = 8'd4;
  logic oscEn, cpuClkEn, resumeNext, takeVector, resetReq;
  logic [1:0] pmMode;
  logic [NIRQ-1:0] pendFlags;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_wake_ctrl #(.NUM_IRQ(NIRQ), .WARM_W(WW)) u_pwr_wake_ctrl (
    .clk(clk), .rstN(rstN), .sleepInsn(sleepInsn), .modeSel(modeSel),
    .edgeMode(edgeMode), .sleepPinN(sleepPinN), .resetPinN(resetPinN),
    .wdtTimeout(wdtTimeout), .wdtIrq(wdtIrq), .irqReq(irqReq), .irqEn(irqEn),
    .globalIe(globalIe), .flagClr(flagClr), .warmLen(warmLen), .oscEn(oscEn),
    .cpuClkEn(cpuClkEn), .pmMode(pmMode), .resumeNext(resumeNext),
    .takeVector(takeVector), .resetReq(resetReq), .pendFlags(pendFlags)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  // status word: {oscEn, cpuClkEn, pmMode}
  function automatic int stat();
    return int'({oscEn, cpuClkEn, pmMode});
  endfunction

  task automatic sleepCycle(input bit edg, input int w, input bit collide);
    int len;
    len = (w < 1) ? 1 : w;
    edgeMode = edg;
    warmLen = WW'(w);
    sleepPinN = edg ? 1'b1 : 1'b0;
    repeat (3) begin tick(); chk("R7 pin in Normal", pmMode, 0); end
    sleepInsn = 1'b1; modeSel = 1'b1;
    tick();
    sleepInsn = 1'b0; modeSel = 1'b0;
    chk("R3 sleep entry", stat(), 2);
    irqReq = '1; irqEn = '1; wdtIrq = 1'b1; globalIe = edg;
    tick();
    chk("R8 irq in Sleep", pmMode, 2);
    irqReq = '0; irqEn = '0; wdtIrq = 1'b0; globalIe = 1'b0;
    sleepPinN = edg ? 1'b0 : 1'b1;
    tick(); tick();
    chk("R5 two edges", pmMode, 2);
    tick();
    chk("R5 third edge", pmMode, 3);
    chk("R6 warm enables", {oscEn, cpuClkEn}, 2);
    irqReq = '1; irqEn = '1; wdtIrq = 1'b1;
    for (int k = 1; k < len; k++) begin
      tick();
      chk("R6 still warm", stat(), 3 | 8);
      chk("R8 irq in warm-up", takeVector, 0);
    end
    irqReq = '0; irqEn = '0; wdtIrq = 1'b0;
    if (collide) begin
      wdtTimeout = 1'b1;
      tick();
      wdtTimeout = 1'b0;
      chk("R10 reset vs warm end mode", stat(), 12);
      chk("R10 resetReq", resetReq, 1);
      chk("R10 no resume", resumeNext, 0);
    end else begin
      tick();
      chk("R6 back to Normal", stat(), 12);
      chk("R6 resume pulse", resumeNext, 1);
      chk("R11 exclusive", takeVector, 0);
    end
    tick();
    chk("R6 pulse one cycle", resumeNext | (resetReq << 1), 0);
    sleepPinN = 1'b1;
    flagClr = '1; tick(); flagClr = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      finishRun();
    end
  end

  initial begin
    repeat (3) tick();
    chk("R1 reset status", stat(), 12);
    rstN = 1'b1;
    tick();
    chk("R1 status", stat(), 12);
    chk("R1 pulses", int'({resumeNext, takeVector, resetReq}), 0);
    chk("R1 flags", pendFlags, 0);

    // R4: level mode, pin high: refused
    edgeMode = 1'b0; sleepPinN = 1'b1;
    repeat (3) tick();
    sleepInsn = 1'b1; modeSel = 1'b1;
    tick();
    sleepInsn = 1'b0; modeSel = 1'b0;
    chk("R4 refused", stat(), 12);
    tick();
    chk("R4 refused hold", pmMode, 0);

    // R5/R6 sweep over mode and warm length
    for (int e = 0; e < 2; e++)
      for (int w = 0; w < 6; w++)
        sleepCycle(e[0], w, 1'b0);
    // R10 collision with warm-up end
    sleepCycle(1'b1, 3, 1'b1);

    // R9 sweep: idle wake over enable, source, global enable
    for (int g = 0; g < 2; g++)
      for (int src = 0; src <= NIRQ; src++)
        for (int en = 0; en < 2; en++) begin
          bit wake;
          wake = (en == 1) || (src == NIRQ);
          sleepInsn = 1'b1; modeSel = 1'b0;
          tick();
          sleepInsn = 1'b0;
          chk("R2 idle entry", stat(), 9);
          globalIe = g[0];
          irqEn = en[0] ? '1 : '0;
          if (src == NIRQ) wdtIrq = 1'b1;
          else irqReq[src] = 1'b1;
          tick();
          irqReq = '0; wdtIrq = 1'b0;
          chk("R9 wake mode", pmMode, wake ? 0 : 1);
          chk("R9 resume", resumeNext, (wake && g == 0) ? 1 : 0);
          chk("R9 vector", takeVector, (wake && g == 1) ? 1 : 0);
          if (src < NIRQ) chk("R8 flag recorded", pendFlags, 1 << src);
          if (!wake) begin
            wdtIrq = 1'b1; tick(); wdtIrq = 1'b0;
            chk("R9 wdt irq wake", pmMode, 0);
          end
          irqEn = '0; globalIe = 1'b0;
          flagClr = '1; tick(); flagClr = '0;
          chk("R8 flag cleared", pendFlags, 0);
        end

    // R8: set beats clear
    irqReq = 4'b0110; flagClr = 4'b0010;
    tick();
    irqReq = '0; flagClr = '0;
    chk("R8 set over clear", pendFlags, 6);
    flagClr = '1; tick(); flagClr = '0;

    // R7: pin in Idle
    edgeMode = 1'b1;
    sleepInsn = 1'b1; modeSel = 1'b0; tick(); sleepInsn = 1'b0;
    sleepPinN = 1'b0;
    repeat (4) begin tick(); chk("R7 pin low in Idle", pmMode, 1); end
    edgeMode = 1'b0; sleepPinN = 1'b1;
    repeat (4) begin tick(); chk("R7 pin high in Idle", pmMode, 1); end

    // R10: reset pin collides with idle vector wake
    irqReq = 4'b0001; irqEn = 4'b0001; globalIe = 1'b1; resetPinN = 1'b0;
    tick();
    irqReq = '0; irqEn = '0; globalIe = 1'b0; resetPinN = 1'b1;
    chk("R10 reset vs idle wake", stat(), 12);
    chk("R10 resetReq pin", resetReq, 1);
    chk("R10 no vector", takeVector, 0);
    tick();
    chk("R10 resetReq drops", resetReq, 0);
    flagClr = '1; tick(); flagClr = '0;

    // R10: reset pin in Sleep
    edgeMode = 1'b1;
    sleepInsn = 1'b1; modeSel = 1'b1; tick(); sleepInsn = 1'b0; modeSel = 1'b0;
    chk("R3 edge entry pin high", stat(), 2);
    resetPinN = 1'b0; tick(); resetPinN = 1'b1;
    chk("R10 reset from Sleep", stat(), 12);
    chk("R10 resetReq sleep", resetReq, 1);
    tick();

    finishRun();
  end

endmodule